// File: doc/BRIEF.md
# Card Data Word FIFO Pair with Transfer Requests

This block sits between the register side of a memory-card host controller and its card-side serializer. It holds two 32-bit word queues. The transmit queue is filled from the register side and drained by the card side. The receive queue is filled by the card side and drained from the register side. The register side may be served either by an external DMA engine or by software polling. A mode input selects which one. The same fixed 8-word watermarks then drive either the DMA request lines or the programmed-I/O interrupt flags.

Loading a command that carries data empties both queues and clears their error bits. From reset, every request and flag stays quiet until the first such command has been loaded. Each queue also reports its occupancy, full, empty and a sticky error bit.

The block also turns the transfer byte length into two values:
- the number of 32-byte bursts, rounded up;
- the byte lanes that are valid in the final word.

Byte k of a word travels in bits 8k+7:8k.

Top module: `card_data_fifo`

## Requirements
- R1: Each queue stores 32-bit words and returns them in the order written. Transmit words enter through regWrData and leave on cardPopData. Receive words enter through cardPushData and leave on regRdData. Read data is presented first-word fall-through.
- R2: rxDmaReq is 1 exactly when the block is armed, dmaMode is 1 and rxCount is 8 or more.
- R3: txDmaReq is 1 exactly when the block is armed, dmaMode is 1 and txCount is below 8.
- R4: When dmaMode is 0, both DMA request lines are 0. In that mode the same two conditions drive rxRdReqFlag and txWrReqFlag instead. When dmaMode is 1, both flags are 0.
- R5: A cycle with cmdLoad=1 and cmdDataEn=1 empties both queues and clears both error bits at that clock edge. Any push or pop in the same cycle is dropped. A cmdLoad with cmdDataEn=0 changes nothing.
- R6: From reset until the first cycle after a command with data, all four request and flag outputs are 0.
- R7: burstCount equals (byteCount + 31) / 32, using integer division.
- R8: lastLaneMask bit k is 1 when byte lane k of the final word holds data. The mask is 4'b1111 when byteCount mod 4 is 0, and (1 << (byteCount mod 4)) - 1 otherwise. It is 4'b0000 when byteCount is 0.
- R9: Each queue holds 16 words. A push while full and a pop while empty leave the contents and the count unchanged. Full and empty report the count being 16 and 0.
- R10: txErr becomes 1 after a register write while the transmit queue is full, or a card pop while it is empty. rxErr becomes 1 after a card push while the receive queue is full, or a register read while it is empty. Each bit stays 1 until a command with data.
- R11: txCount and rxCount give the 5-bit occupancy one edge after each accepted push or pop. The requests and flags follow the count in that same cycle.
- R12: After reset both counts are 0, both empty flags are 1, and both error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dmaMode | input | 1 | 1 selects DMA requests, 0 selects programmed-I/O flags |
| cmdLoad | input | 1 | Command register written this cycle |
| cmdDataEn | input | 1 | Loaded command carries data |
| regWr | input | 1 | Register-side write into the transmit queue |
| regWrData | input | 32 | Word written into the transmit queue |
| regRd | input | 1 | Register-side read from the receive queue |
| regRdData | output | 32 | Head word of the receive queue |
| cardPush | input | 1 | Card-side push into the receive queue |
| cardPushData | input | 32 | Word pushed into the receive queue |
| cardPop | input | 1 | Card-side pop from the transmit queue |
| cardPopData | output | 32 | Head word of the transmit queue |
| byteCount | input | 16 | Transfer length in bytes |
| burstCount | output | 12 | Number of 32-byte bursts |
| lastLaneMask | output | 4 | Valid byte lanes of the final word |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txWrReqFlag | output | 1 | Programmed-I/O transmit write request flag |
| rxRdReqFlag | output | 1 | Programmed-I/O receive read request flag |
| txCount | output | 5 | Transmit occupancy |
| rxCount | output | 5 | Receive occupancy |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| txErr | output | 1 | Sticky transmit overflow or underflow |
| rxErr | output | 1 | Sticky receive overflow or underflow |

## Verification
Occupancy, error bits and queue heads change at the first clock edge that samples a push, pop or command. Full, empty, requests and flags are decoded from the occupancy without a further register, so they settle in that same cycle. burstCount and lastLaneMask have no register at all. The bench drives every input 1 ns after a rising edge and checks the state results 1 ns after the next rising edge. It checks the byte-count results 1 ns after changing the input, with no edge in between.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic clr;
  } fifoStrobes_t;
endpackage

// File: rtl/cdf_fifo.sv
module cdf_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrWord,
  output logic [WIDTH-1:0] rdWord,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  // storage has no reset; only pointers carry state
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdWord = mem[rdPtr];
  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
endmodule

// File: rtl/cdf_datapath.sv
module cdf_datapath
  import cdf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WMARK   = 8,
  parameter int BYTE_W  = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int BURST_B = WMARK * WORD_W / 8,
  localparam int SH      = $clog2(BURST_B),
  localparam int BURST_W = BYTE_W + 1 - SH,
  localparam int LSH     = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobes_t       strobes,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [WORD_W-1:0]  cardPushData,
  output logic [WORD_W-1:0]  regRdData,
  output logic [WORD_W-1:0]  cardPopData,
  input  logic [BYTE_W-1:0]  byteCount,
  output logic [BURST_W-1:0] burstCount,
  output logic [LANES-1:0]   lastLaneMask,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic               txFull,
  output logic               txEmpty,
  output logic               rxFull,
  output logic               rxEmpty
);
  // index 0 = transmit queue, index 1 = receive queue
  logic [1:0]        qPush, qPop, qFull, qEmpty;
  logic [WORD_W-1:0] qIn  [2];
  logic [WORD_W-1:0] qOut [2];
  logic [CNT_W-1:0]  qCnt [2];

  assign qPush  = {strobes.rxPush, strobes.txPush};
  assign qPop   = {strobes.rxPop,  strobes.txPop};
  assign qIn[0] = regWrData;
  assign qIn[1] = cardPushData;

  for (genvar g = 0; g < 2; g++) begin : gQueue
    cdf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) uFifo (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strobes.clr),
      .push   (qPush[g]),
      .pop    (qPop[g]),
      .wrWord (qIn[g]),
      .rdWord (qOut[g]),
      .count  (qCnt[g]),
      .full   (qFull[g]),
      .empty  (qEmpty[g])
    );
  end

  assign cardPopData = qOut[0];
  assign regRdData   = qOut[1];
  assign txCount     = qCnt[0];
  assign rxCount     = qCnt[1];
  assign txFull      = qFull[0];
  assign txEmpty     = qEmpty[0];
  assign rxFull      = qFull[1];
  assign rxEmpty     = qEmpty[1];

  // burst count rounded up
  logic [BYTE_W:0] roundedBytes;
  assign roundedBytes = {1'b0, byteCount} + (BYTE_W + 1)'(BURST_B - 1);
  assign burstCount   = roundedBytes[BYTE_W:SH];

  // valid byte lanes of the final word
  logic [LSH-1:0] tailBytes;
  logic           anyBytes;
  assign tailBytes = byteCount[LSH-1:0];
  assign anyBytes  = (byteCount != '0);

  for (genvar k = 0; k < LANES; k++) begin : gLane
    assign lastLaneMask[k] = anyBytes &&
                             ((tailBytes == '0) || (LSH'(k) < tailBytes));
  end
endmodule

// File: rtl/cdf_ctrl.sv
module cdf_ctrl
  import cdf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WMARK = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaMode,
  input  logic             cmdLoad,
  input  logic             cmdDataEn,
  input  logic             regWr,
  input  logic             regRd,
  input  logic             cardPush,
  input  logic             cardPop,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStrobes_t     strobes,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             txWrReqFlag,
  output logic             rxRdReqFlag,
  output logic             txErr,
  output logic             rxErr
);
  logic clrNow, armed, txBelow, rxAbove;
  logic txBad, rxBad;

  assign clrNow = cmdLoad && cmdDataEn;

  always_comb begin
    strobes        = '0;
    strobes.clr    = clrNow;
    strobes.txPush = regWr    && !txFull  && !clrNow;
    strobes.txPop  = cardPop  && !txEmpty && !clrNow;
    strobes.rxPush = cardPush && !rxFull  && !clrNow;
    strobes.rxPop  = regRd    && !rxEmpty && !clrNow;
  end

  assign txBad = (regWr && txFull) || (cardPop && txEmpty);
  assign rxBad = (cardPush && rxFull) || (regRd && rxEmpty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      txErr <= 1'b0;
      rxErr <= 1'b0;
    end else if (clrNow) begin
      armed <= 1'b1;
      txErr <= 1'b0;
      rxErr <= 1'b0;
    end else begin
      if (txBad) txErr <= 1'b1;
      if (rxBad) rxErr <= 1'b1;
    end
  end

  // watermark decode straight from the occupancy, no extra register
  assign txBelow = txCount <  CNT_W'(WMARK);
  assign rxAbove = rxCount >= CNT_W'(WMARK);

  assign txDmaReq    = armed &&  dmaMode && txBelow;
  assign rxDmaReq    = armed &&  dmaMode && rxAbove;
  assign txWrReqFlag = armed && !dmaMode && txBelow;
  assign rxRdReqFlag = armed && !dmaMode && rxAbove;
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
  import cdf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WMARK  = 8,
  parameter int BYTE_W = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int BURST_W = BYTE_W + 1 - $clog2(WMARK * WORD_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dmaMode,
  input  logic               cmdLoad,
  input  logic               cmdDataEn,
  input  logic               regWr,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic               regRd,
  output logic [WORD_W-1:0]  regRdData,
  input  logic               cardPush,
  input  logic [WORD_W-1:0]  cardPushData,
  input  logic               cardPop,
  output logic [WORD_W-1:0]  cardPopData,
  input  logic [BYTE_W-1:0]  byteCount,
  output logic [BURST_W-1:0] burstCount,
  output logic [LANES-1:0]   lastLaneMask,
  output logic               txDmaReq,
  output logic               rxDmaReq,
  output logic               txWrReqFlag,
  output logic               rxRdReqFlag,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic               txFull,
  output logic               txEmpty,
  output logic               rxFull,
  output logic               rxEmpty,
  output logic               txErr,
  output logic               rxErr
);
  fifoStrobes_t strobes;

  cdf_ctrl #(.DEPTH(DEPTH), .WMARK(WMARK)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .dmaMode     (dmaMode),
    .cmdLoad     (cmdLoad),
    .cmdDataEn   (cmdDataEn),
    .regWr       (regWr),
    .regRd       (regRd),
    .cardPush    (cardPush),
    .cardPop     (cardPop),
    .txFull      (txFull),
    .txEmpty     (txEmpty),
    .rxFull      (rxFull),
    .rxEmpty     (rxEmpty),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .strobes     (strobes),
    .txDmaReq    (txDmaReq),
    .rxDmaReq    (rxDmaReq),
    .txWrReqFlag (txWrReqFlag),
    .rxRdReqFlag (rxRdReqFlag),
    .txErr       (txErr),
    .rxErr       (rxErr)
  );

  cdf_datapath #(.DEPTH(DEPTH), .WMARK(WMARK), .BYTE_W(BYTE_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regWrData    (regWrData),
    .cardPushData (cardPushData),
    .regRdData    (regRdData),
    .cardPopData  (cardPopData),
    .byteCount    (byteCount),
    .burstCount   (burstCount),
    .lastLaneMask (lastLaneMask),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .txFull       (txFull),
    .txEmpty      (txEmpty),
    .rxFull       (rxFull),
    .rxEmpty      (rxEmpty)
  );
endmodule

// File: rtl/cdf_checker.sv
module cdf_checker #(
  parameter int DEPTH = 16,
  parameter int WMARK = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             dmaMode,
  input logic             cmdLoad,
  input logic             cmdDataEn,
  input logic             regWr,
  input logic             cardPop,
  input logic             txDmaReq,
  input logic             rxDmaReq,
  input logic             txWrReqFlag,
  input logic             rxRdReqFlag,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             txFull,
  input logic             txErr,
  input logic             rxErr
);
  // R4
  pio_no_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dmaMode |-> (!txDmaReq && !rxDmaReq));

  // R4
  dma_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaMode |-> (!txWrReqFlag && !rxRdReqFlag));

  // R2
  rx_req_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> (rxCount >= CNT_W'(WMARK)));

  // R3
  tx_req_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (txCount < CNT_W'(WMARK)));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoad && cmdDataEn) |=> (txCount == '0 && rxCount == '0 && !txErr && !rxErr));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && txFull && !cardPop && !(cmdLoad && cmdDataEn)) |=> txFull);

  // R10
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !(cmdLoad && cmdDataEn)) |=> txErr);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));
endmodule

bind card_data_fifo cdf_checker #(.DEPTH(DEPTH), .WMARK(WMARK)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .dmaMode     (dmaMode),
  .cmdLoad     (cmdLoad),
  .cmdDataEn   (cmdDataEn),
  .regWr       (regWr),
  .cardPop     (cardPop),
  .txDmaReq    (txDmaReq),
  .rxDmaReq    (rxDmaReq),
  .txWrReqFlag (txWrReqFlag),
  .rxRdReqFlag (rxRdReqFlag),
  .txCount     (txCount),
  .rxCount     (rxCount),
  .txFull      (txFull),
  .txErr       (txErr),
  .rxErr       (rxErr)
);

// File: tb/tb_card_data_fifo.sv
module tb_card_data_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaMode = 1'b1, cmdLoad = 1'b0, cmdDataEn = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0, cardPush = 1'b0, cardPop = 1'b0;
  logic [31:0] regWrData = '0, cardPushData = '0;
  logic [31:0] regRdData, cardPopData;
  logic [15:0] byteCount = '0;
  logic [11:0] burstCount;
  logic [3:0]  lastLaneMask;
  logic txDmaReq, rxDmaReq, txWrReqFlag, rxRdReqFlag;
  logic [4:0] txCount, rxCount;
  logic txFull, txEmpty, rxFull, rxEmpty, txErr, rxErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  card_data_fifo dut (.*);

  function automatic logic [31:0] pat(input int n, input int salt);
    return (32'h1000_0001 * (n + 1)) ^ (32'h5A00_00A5 + 32'(salt));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FIFO-BENCH FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs are set 1 ns after an edge; results read 1 ns after the next edge
  task automatic tick();
    @(posedge clk);
    #1;
    cmdLoad = 0; cmdDataEn = 0; regWr = 0; regRd = 0; cardPush = 0; cardPop = 0;
  endtask

  task automatic dataCmd();
    cmdLoad = 1; cmdDataEn = 1; tick();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FIFO-BENCH FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // R12 reset state
    chk("R12 txCount", txCount, 0);
    chk("R12 rxCount", rxCount, 0);
    chk("R12 empties", {txEmpty, rxEmpty}, 2'b11);
    chk("R12 errors", {txErr, rxErr}, 0);
    // R6 masked before any data command, though tx is below watermark
    chk("R6 txDmaReq unarmed", txDmaReq, 0);
    chk("R6 flags unarmed", {txWrReqFlag, rxRdReqFlag, rxDmaReq}, 0);

    // R5 a command without data changes nothing
    for (int i = 0; i < 3; i++) begin regWr = 1; regWrData = pat(i, 9); tick(); end
    cmdLoad = 1; cmdDataEn = 0; tick();
    chk("R5 no-data cmd keeps count", txCount, 3);
    chk("R6 still unarmed", txDmaReq, 0);
    // R5 data command with push in same cycle: push dropped
    regWr = 1; regWrData = 32'hDEAD; dataCmd();
    chk("R5 clear tx", txCount, 0);
    chk("R3 armed txDmaReq", txDmaReq, 1);

    // transmit fill sweep, DMA mode
    for (int n = 1; n <= 16; n++) begin
      regWr = 1; regWrData = pat(n, 1); tick();
      chk("R11 txCount", txCount, n);
      chk("R3 txDmaReq vs level", txDmaReq, (n < 8));
      chk("R9 txFull", txFull, (n == 16));
    end
    regWr = 1; regWrData = 32'hBAD0; tick();
    chk("R9 overflow count", txCount, 16);
    chk("R10 txErr on overflow", txErr, 1);
    // R1 drain in order
    for (int n = 1; n <= 16; n++) begin
      chk("R1 tx order", cardPopData, pat(n, 1));
      cardPop = 1; tick();
      chk("R11 txCount drain", txCount, 16 - n);
      chk("R3 txDmaReq drain", txDmaReq, ((16 - n) < 8));
    end
    chk("R9 txEmpty", txEmpty, 1);
    cardPop = 1; tick();
    chk("R9 underflow count", txCount, 0);
    chk("R10 txErr sticky", txErr, 1);

    // receive fill sweep
    for (int n = 1; n <= 16; n++) begin
      cardPush = 1; cardPushData = pat(n, 2); tick();
      chk("R11 rxCount", rxCount, n);
      chk("R2 rxDmaReq vs level", rxDmaReq, (n >= 8));
      chk("R9 rxFull", rxFull, (n == 16));
    end
    cardPush = 1; cardPushData = 32'hBAD1; tick();
    chk("R9 rx overflow count", rxCount, 16);
    chk("R10 rxErr on overflow", rxErr, 1);
    for (int n = 1; n <= 16; n++) begin
      chk("R1 rx order", regRdData, pat(n, 2));
      regRd = 1; tick();
      chk("R2 rxDmaReq drain", rxDmaReq, ((16 - n) >= 8));
    end
    // simultaneous push and pop on tx keeps count
    regWr = 1; regWrData = pat(40, 3); tick();
    regWr = 1; regWrData = pat(41, 3); cardPop = 1; tick();
    chk("R11 push+pop count", txCount, 1);
    chk("R1 push+pop head", cardPopData, pat(41, 3));

    // R4 programmed-I/O mode; R5 errors cleared
    dmaMode = 0;
    dataCmd();
    chk("R5 errs cleared", {txErr, rxErr}, 0);
    chk("R5 tx emptied", txCount, 0);
    chk("R4 txWrReqFlag", txWrReqFlag, 1);
    chk("R4 no tx dma", txDmaReq, 0);
    for (int n = 1; n <= 8; n++) begin
      cardPush = 1; cardPushData = pat(n, 4); tick();
      chk("R4 rxRdReqFlag", rxRdReqFlag, (n >= 8));
      chk("R4 no rx dma", rxDmaReq, 0);
    end
    dmaMode = 1; #1;
    chk("R4 flags off in dma", {txWrReqFlag, rxRdReqFlag}, 0);
    chk("R2 rx dma on", rxDmaReq, 1);
    regRd = 1; tick();
    chk("R11 rx req drops on crossing", rxDmaReq, 0);

    // R7/R8 byte count sweep
    for (int b = 0; b <= 2100; b++) begin
      byteCount = 16'(b); #1;
      chk("R7 burstCount", burstCount, (b + 31) / 32);
      chk("R8 lastLaneMask", lastLaneMask,
          (b == 0) ? 0 : ((b % 4) == 0) ? 4'hF : ((1 << (b % 4)) - 1));
    end
    byteCount = 16'hFFFF; #1;
    chk("R7 burstCount max", burstCount, (65535 + 31) / 32);
    chk("R8 lastLaneMask max", lastLaneMask, 4'b0111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule